// File: doc/BRIEF.md
# Eight-Input A/D Conversion Sequencer

This block is the digital control around an eight-input analog-to-digital converter. A CPU reaches it through a simple read/write port. It holds one byte-wide control/status register and eight result registers. Software picks a channel code, a conversion speed and single or scan operation, then sets the start bit. The block times every conversion with a counter. When a conversion ends, it latches the converter's 10-bit sample into that channel's result register. After a single conversion, or after a full pass over the selected channels, it raises an end flag, which can request an interrupt.

In single mode the start bit clears itself after one conversion. In scan mode the block steps round a group of one to four channels, taken from the lower or the upper half of the inputs, until software clears the start bit. The end flag is cleared in several ways: a guarded software clear, a service strobe from a transfer controller, entry to standby, or reset. The analog converter is not part of the block; its output arrives on `sample_in`.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, the control/status register at address 8 reads 0, all result registers at addresses 0 to 7 read 0, and `irq` is 0. The register bits are: 7 end flag, 6 interrupt enable, 5 start, 4 scan select, 3 speed select, 2:0 channel code.
- R2: In single mode (bit 4 = 0), setting start converts the channel named by the 3-bit code once. At the end, `sample_in` is loaded into that channel's result register, the end flag is set, and the start bit reads 0.
- R3: A conversion lasts 274 clock cycles with bit 3 = 0 and 138 with bit 3 = 1. The end flag first reads 1 after the (N+1)-th rising edge that follows the edge which writes start = 1.
- R4: In scan mode (bit 4 = 1), code bit 2 selects base channel 0 or 4, and code bits 1:0 plus one give the number of channels. These are converted in ascending order, and no other result register changes.
- R5: In scan mode, conversion repeats round the group while start stays 1. The end flag is set at the end of every pass, and the start bit stays 1.
- R6: Writing 0 to start halts conversion at once. The channel being converted keeps its previous result.
- R7: Writing 1 to bit 7 leaves the flag unchanged. Writing 0 to bit 7 clears the flag only if the last access to address 8 before that write was a read that returned the flag as 1.
- R8: A one-cycle pulse on `xfer_ack` clears the end flag.
- R9: Asserting `standby` clears the end flag and the start bit, and aborts a running conversion without changing its result register.
- R10: `irq` is high exactly when the end flag and the interrupt-enable bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| standby | input | 1 | Standby entry; aborts and clears |
| xfer_ack | input | 1 | Transfer-controller service strobe, clears end flag |
| bus_addr | input | 4 | 0 to 7 result registers, 8 control/status |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (arms the flag clear) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 10 | Read data, combinational from `bus_addr` |
| sample_in | input | 10 | Converter output, latched at conversion end |
| irq | output | 1 | Interrupt request |

## Verification
Single mode is driven from a table that covers both ends of the channel range and both speeds. The `irq` edge is timed to the exact cycle, so a counter that is one off, or that uses the wrong length, shows up. Scan mode is run on the lower four-channel group and on the upper two-channel group, with a distinct sample for every conversion. This tells apart a wrong base, a wrong count, a wrong order and a missing wrap. A comparison of all eight result registers at the end also catches any write to a channel outside the group. Directed sequences cover each way the flag can be cleared or kept, and aborts by a start = 0 write and by standby.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int CH_W = 3;
  localparam int B_FLAG  = 7;
  localparam int B_IE    = 6;
  localparam int B_START = 5;
  localparam int B_SCAN  = 4;
  localparam int B_CKS   = 3;

  // first channel of a run: the code itself in single mode, group base in scan
  function automatic logic [CH_W-1:0] grp_first(input logic scan, input logic [CH_W-1:0] code);
    return scan ? {code[CH_W-1], {(CH_W-1){1'b0}}} : code;
  endfunction

  // last channel of a run equals the code in both modes
  function automatic logic [CH_W-1:0] grp_last(input logic [CH_W-1:0] code);
    return code;
  endfunction

  function automatic int conv_len(input logic cks, input int slow, input int fast);
    return cks ? fast : slow;
  endfunction
endpackage

// File: rtl/adc_ctrl_reg.sv
module adc_ctrl_reg
  import adc_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       standby,
  input  logic       wr_csr,
  input  logic       rd_csr,
  input  logic [7:0] wdata,
  input  logic       pass_done,
  input  logic       single_done,
  input  logic       xfer_ack,
  output logic [7:0] csr
);
  logic flag, ie, start, scan, cks, armed;
  logic [CH_W-1:0] code;
  logic flag_clr;

  assign flag_clr = xfer_ack | (wr_csr & ~wdata[B_FLAG] & armed);
  assign csr = {flag, ie, start, scan, cks, code};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag <= 1'b0; ie <= 1'b0; start <= 1'b0; scan <= 1'b0;
      cks <= 1'b0; code <= '0; armed <= 1'b0;
    end else if (standby) begin
      flag <= 1'b0; start <= 1'b0; armed <= 1'b0;
    end else begin
      if (wr_csr) begin
        ie    <= wdata[B_IE];
        start <= wdata[B_START];
        scan  <= wdata[B_SCAN];
        cks   <= wdata[B_CKS];
        code  <= wdata[CH_W-1:0];
        armed <= 1'b0;
      end else begin
        if (single_done) start <= 1'b0;
        if (rd_csr) armed <= flag;
      end
      if (pass_done)     flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
    end
  end

  assert_flag_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_done && !standby) |=> flag);
  assert_standby_R9: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> (!flag && !start));
  assert_w1_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_csr && wdata[B_FLAG] && flag && !xfer_ack && !standby) |=> flag);
  assert_unarmed_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_csr && !armed && flag && !xfer_ack && !standby) |=> flag);
  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_ack && !pass_done) |=> !flag);
endmodule

// File: rtl/adc_seq_engine.sv
module adc_seq_engine
  import adc_seq_pkg::*;
#(
  parameter int LEN_SLOW = 274,
  parameter int LEN_FAST = 138
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            standby,
  input  logic            start,
  input  logic            scan,
  input  logic            cks,
  input  logic [CH_W-1:0] code,
  output logic            busy,
  output logic [CH_W-1:0] cur_ch,
  output logic            conv_done,
  output logic            pass_done
);
  localparam int LEN_MAX = (LEN_SLOW > LEN_FAST) ? LEN_SLOW : LEN_FAST;
  localparam int CNT_W   = $clog2(LEN_MAX);

  logic [CNT_W-1:0] cnt, last_cnt;
  logic             wrap;

  assign last_cnt  = CNT_W'(conv_len(cks, LEN_SLOW, LEN_FAST) - 1);
  assign conv_done = busy & start & (cnt >= last_cnt);
  assign wrap      = cur_ch >= grp_last(code);
  assign pass_done = conv_done & (~scan | wrap);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; cnt <= '0; cur_ch <= '0;
    end else if (standby || !start) begin
      busy <= 1'b0; cnt <= '0;
    end else if (!busy) begin
      busy <= 1'b1; cnt <= '0; cur_ch <= grp_first(scan, code);
    end else if (conv_done) begin
      cnt <= '0;
      if (scan) cur_ch <= wrap ? grp_first(1'b1, code) : cur_ch + 1'b1;
      else      busy   <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assert_abort_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!start || standby) |=> !busy);
  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (int'(cnt) < LEN_MAX));
  assert_single_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !scan) |=> !busy);
  assert_scan_cont_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && scan && !standby) |=> busy);
  assert_scan_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && scan && $stable(code)) |-> (cur_ch[CH_W-1] == code[CH_W-1]));
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
  parameter int CH_W  = 3,
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CH_W-1:0]  sel,
  input  logic [RES_W-1:0] din,
  input  logic [CH_W-1:0]  rd_sel,
  output logic [RES_W-1:0] rd_val
);
  localparam int NCH = 1 << CH_W;
  logic [RES_W-1:0] regs [NCH];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n)                              regs[i] <= '0;
      else if (load && sel == CH_W'(i))        regs[i] <= din;
    end
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(load && sel == CH_W'(i)) |=> $stable(regs[i]));
  end

  assign rd_val = regs[rd_sel];

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (regs[$past(sel)] == $past(din)));
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int RES_W    = 10,
  parameter int LEN_SLOW = 274,
  parameter int LEN_FAST = 138
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             standby,
  input  logic             xfer_ack,
  input  logic [3:0]       bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [7:0]       bus_wdata,
  output logic [RES_W-1:0] bus_rdata,
  input  logic [RES_W-1:0] sample_in,
  output logic             irq
);
  localparam int NCH = 1 << CH_W;

  logic            sel_csr, wr_csr, rd_csr;
  logic [7:0]      csr;
  logic            busy, conv_done, pass_done, single_done;
  logic [CH_W-1:0] cur_ch;
  logic [RES_W-1:0] res_val;

  assign sel_csr     = bus_addr == 4'(NCH);
  assign wr_csr      = bus_wr & sel_csr;
  assign rd_csr      = bus_rd & sel_csr;
  assign single_done = conv_done & ~csr[B_SCAN];

  adc_ctrl_reg u_reg (
    .clk(clk), .rst_n(rst_n), .standby(standby), .wr_csr(wr_csr), .rd_csr(rd_csr),
    .wdata(bus_wdata), .pass_done(pass_done), .single_done(single_done),
    .xfer_ack(xfer_ack), .csr(csr));

  adc_seq_engine #(.LEN_SLOW(LEN_SLOW), .LEN_FAST(LEN_FAST)) u_eng (
    .clk(clk), .rst_n(rst_n), .standby(standby), .start(csr[B_START]),
    .scan(csr[B_SCAN]), .cks(csr[B_CKS]), .code(csr[CH_W-1:0]),
    .busy(busy), .cur_ch(cur_ch), .conv_done(conv_done), .pass_done(pass_done));

  adc_result_bank #(.CH_W(CH_W), .RES_W(RES_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .load(conv_done), .sel(cur_ch), .din(sample_in),
    .rd_sel(bus_addr[CH_W-1:0]), .rd_val(res_val));

  assign bus_rdata = sel_csr ? {{(RES_W-8){1'b0}}, csr} :
                     bus_addr[3] ? '0 : res_val;
  assign irq = csr[B_FLAG] & csr[B_IE];

  assert_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_done && csr[B_IE] && !standby) |=> irq);
endmodule

// File: tb/sim_adc_seq_ctrl.sv
`timescale 1ns/1ps
module sim_adc_seq_ctrl;
  logic clk = 1'b0, rst_n = 1'b0, standby = 1'b0, xfer_ack = 1'b0;
  logic [3:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [9:0] bus_rdata, sample_in = '0;
  logic irq;
  int n_run = 0, n_fail = 0;
  logic [9:0] model [8];

  localparam int SLOW = 274, FAST = 138;
  // {speed, channel, sample}
  localparam logic [13:0] VEC [6] = '{
    {1'b0, 3'd0, 10'h2A5}, {1'b1, 3'd7, 10'h3FF}, {1'b1, 3'd3, 10'h001},
    {1'b0, 3'd5, 10'h15A}, {1'b1, 3'd0, 10'h0F0}, {1'b0, 3'd6, 10'h30C}};

  always #2 clk = ~clk;

  adc_seq_ctrl u0 (.clk(clk), .rst_n(rst_n), .standby(standby), .xfer_ack(xfer_ack),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .sample_in(sample_in), .irq(irq));

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output int v);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1; #1 v = int'(bus_rdata);
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_all(input string req);
    int v;
    for (int c = 0; c < 8; c++) begin
      rd(4'(c), v);
      chk(req, v, int'(model[c]));
    end
  endtask

  // scan run: ncv conversions, then abort and flag-clear sequence
  task automatic scan_run(input logic [2:0] code, input logic cks, input int ncv);
    int len, cnt, first, v;
    len = cks ? FAST : SLOW;
    cnt = int'(code[1:0]) + 1;
    first = code[2] ? 4 : 0;
    wr(4'd8, 8'h70 | (8'(cks) << 3) | 8'(code));
    @(posedge clk); @(negedge clk);
    for (int k = 0; k < ncv; k++) begin
      logic [9:0] s;
      s = 10'(10'h111 + k * 53 + int'(code) * 7);
      sample_in = s;
      repeat (len) @(posedge clk);
      @(negedge clk);
      model[first + (k % cnt)] = s;
      if (k == 0 && cnt > 1) chk("R5 no flag mid-pass", int'(irq), 0);
      if ((k % cnt) == cnt - 1) chk("R5 flag at pass end", int'(irq), 1);
    end
    sample_in = 10'h3C3;
    idle(20);
    rd(4'd8, v);
    chk("R5 start stays 1 in scan", v, 'hF0 | (int'(cks) << 3) | int'(code));
    wr(4'd8, 8'hC0);            // R6 abort with bit7=1
    idle(SLOW + 10);
    chk("R7 write 1 keeps flag", int'(irq), 1);
    check_all("R4/R6 results after scan and abort");
    wr(4'd8, 8'h40);
    chk("R7 clear without read ignored", int'(irq), 1);
    rd(4'd8, v);
    wr(4'd8, 8'h40);
    chk("R7 read-1 then write-0 clears", int'(irq), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R1-all actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int v;
    for (int c = 0; c < 8; c++) model[c] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state
    rd(4'd8, v); chk("R1 csr reset", v, 0);
    chk("R1 irq reset", int'(irq), 0);
    check_all("R1 results reset");

    // R2/R3 single-mode vector table
    for (int i = 0; i < 6; i++) begin
      logic cks; logic [2:0] ch; int len;
      cks = VEC[i][13]; ch = VEC[i][12:10]; len = cks ? FAST : SLOW;
      sample_in = VEC[i][9:0];
      wr(4'd8, 8'h60 | (8'(cks) << 3) | 8'(ch));
      repeat (len) @(posedge clk); @(negedge clk);
      chk("R3 flag not before N+1 edges", int'(irq), 0);
      @(posedge clk); @(negedge clk);
      chk("R3 flag at N+1 edges", int'(irq), 1);
      model[ch] = VEC[i][9:0];
      rd(4'(ch), v); chk("R2 result loaded", v, int'(VEC[i][9:0]));
      rd(4'd8, v); chk("R2 start self-clears", v, 'hC0 | (int'(cks) << 3) | int'(ch));
      wr(4'd8, 8'h40);
      chk("R7 guarded clear", int'(irq), 0);
    end
    idle(SLOW + 5);
    chk("R2 single runs only once", int'(irq), 0);

    // R4/R5/R6 scan groups
    scan_run(3'b011, 1'b1, 6);
    scan_run(3'b101, 1'b0, 4);

    // R8 transfer strobe
    sample_in = 10'h0AA;
    wr(4'd8, 8'h68 | 8'd2);
    idle(FAST + 5);
    chk("R8 flag set before strobe", int'(irq), 1);
    model[2] = 10'h0AA;
    xfer_ack = 1'b1; @(negedge clk); xfer_ack = 1'b0;
    chk("R8 strobe clears flag", int'(irq), 0);

    // R10 mask
    sample_in = 10'h1BD;
    wr(4'd8, 8'h28 | 8'd3);
    idle(FAST + 5);
    chk("R10 irq masked", int'(irq), 0);
    model[3] = 10'h1BD;
    rd(4'd8, v); chk("R10 flag set while masked", v, 'h8B);
    wr(4'd8, 8'h40);
    chk("R10 irq follows flag and enable", int'(irq), 0);

    // R9 standby abort
    sample_in = 10'h2EE;
    wr(4'd8, 8'h60 | 8'd1);
    idle(100);
    standby = 1'b1; @(negedge clk); standby = 1'b0;
    rd(4'd8, v); chk("R9 standby clears start", v, 'h41);
    idle(SLOW + 10);
    chk("R9 no completion after standby", int'(irq), 0);
    rd(4'd1, v); chk("R9 aborted result unchanged", v, int'(model[1]));
    // R9 standby clears a set flag
    wr(4'd8, 8'h68 | 8'd4);
    idle(FAST + 5);
    model[4] = 10'h2EE;
    chk("R9 flag set before standby", int'(irq), 1);
    standby = 1'b1; @(negedge clk); standby = 1'b0;
    chk("R9 standby clears flag", int'(irq), 0);
    check_all("R6/R9 final result map");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule